// File: doc/BRIEF.md
# Destination Address Hash Filter

This block decides whether an incoming frame is kept by looking only at its 48-bit destination address. The six address bytes arrive one per strobe in the order they come off the wire. The block folds the address into a 6-bit index that selects one bit of a 64-bit hash table, and it compares the address with a configured station address. It then combines these results with per-class hash enables, a broadcast-reject flag and a copy-all (promiscuous) flag.

The verdict appears one clock after the sixth byte is strobed. It is a single-cycle valid pulse that comes with an accept flag and a code naming the rule that won. The accept flag and code keep their values until the next verdict. The block does not parse the rest of the frame, and it has no software-visible state of its own. The table, station address and flags are plain inputs that the surrounding register block drives.

Top module: `da_hash_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following cycle shows `res_vld`=0, `accept`=0 and `match_kind`=0.
- R2: `res_vld` pulses high for exactly one cycle, in the cycle after the edge that takes the sixth address byte. `accept` and `match_kind` change only together with that pulse.
- R3: Address bytes are numbered in arrival order, 0 to 5, and byte k occupies da[8k+7:8k], so da[0] is the lowest bit of the first byte. An exact match of da against {`sta_hi`,`sta_lo`} (byte 0 = `sta_lo`[7:0], byte 5 = `sta_hi`[15:8]) accepts with `match_kind`=1.
- R4: Bit n of the hash index (n = 0..5) is the XOR of da[n+6i] for i = 0..7. The selected table bit is `hash_lo`[idx] for idx < 32 and `hash_hi`[idx-32] otherwise.
- R5: If da[0]=1, `mc_hash_en`=1 and the selected table bit is set, the frame is accepted with `match_kind`=3. `uc_hash_en` has no effect when da[0]=1.
- R6: If da[0]=0, `uc_hash_en`=1 and the selected table bit is set, the frame is accepted with `match_kind`=3. `mc_hash_en` has no effect when da[0]=0.
- R7: An all-ones destination with `no_bcast`=0 is accepted with `match_kind`=2.
- R8: An all-ones destination with `no_bcast`=1 is rejected, even when a hash match or a station match would otherwise accept it.
- R9: With `copy_all`=1 every frame is accepted with `match_kind`=4, whatever the other inputs are. This includes a broadcast while `no_bcast`=1.
- R10: Strobes after the sixth byte are ignored until the next `sof`. A strobe that comes with `sof` is byte 0, and `sof` abandons any partly collected address.
- R11: When no rule matches, `accept`=0 and `match_kind`=0. The priority order is copy-all, then broadcast, then station, then hash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof | input | 1 | Start of a new address; the byte strobed with it is byte 0 |
| byte_vld | input | 1 | Address byte strobe |
| byte_in | input | 8 | Address byte |
| hash_lo | input | 32 | Hash table bits 31:0 |
| hash_hi | input | 32 | Hash table bits 63:32 |
| sta_lo | input | 32 | Station address bytes 0..3 (byte 0 in bits 7:0) |
| sta_hi | input | 16 | Station address bytes 4..5 (byte 4 in bits 7:0) |
| uc_hash_en | input | 1 | Enable hash matching for unicast (da[0]=0) |
| mc_hash_en | input | 1 | Enable hash matching for multicast (da[0]=1) |
| copy_all | input | 1 | Accept every frame |
| no_bcast | input | 1 | Reject the all-ones destination |
| res_vld | output | 1 | One-cycle verdict strobe |
| accept | output | 1 | Frame accepted |
| match_kind | output | 3 | 0 none, 1 station, 2 broadcast, 3 hash, 4 copy-all |

## Verification
A station address made of six distinct bytes shows that arrival order is mapped to the right bit positions. A sweep of multicast addresses, each with only its own table bit set and then with every bit except that one set, separates a correct index fold from a wrong one and covers both halves of the table. Unicast and multicast addresses are each run under the wrong enable to show that the two enables are kept apart. Broadcast cases with hash and station matches also present, copy-all cases, over-long byte runs and an address restarted by `sof` fix the priority order and the collection rules.

// File: rtl/da_filt_pkg.sv
// Shared types for the destination address filter.
package da_filt_pkg;
    // Which rule produced the verdict; the codes are visible at the top ports.
    typedef enum logic [2:0] {
        MK_NONE    = 3'd0,
        MK_STATION = 3'd1,
        MK_BCAST   = 3'd2,
        MK_HASH    = 3'd3,
        MK_PROMISC = 3'd4
    } match_kind_e;
endpackage

// File: rtl/da_addr_collect.sv
// Gathers the destination address bytes in arrival order.
// Assumes: sof marks byte 0 (the byte strobed with it); strobes past the
// last byte are dropped until the next sof. da_now shows the address
// including the byte being strobed this cycle, so a decision can be formed
// combinationally and registered on the same edge that takes the last byte.
module da_addr_collect #(
    parameter int BYTE_W  = 8,
    parameter int N_BYTES = 6,
    localparam int DA_W   = BYTE_W * N_BYTES,
    localparam int CNT_W  = $clog2(N_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [DA_W-1:0]   da_now,
    output logic              last_byte
);
    logic [N_BYTES-1:0][BYTE_W-1:0] held;
    logic [CNT_W-1:0]               cnt;
    logic [CNT_W-1:0]               pos;
    logic                           take;

    // Position of the current strobe and whether it is collected.
    always_comb begin
        pos       = sof ? '0 : cnt;
        take      = byte_vld && (sof || (cnt < CNT_W'(N_BYTES)));
        last_byte = take && (pos == CNT_W'(N_BYTES - 1));
    end

    // Byte counter: restart on sof, saturate after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (take) cnt <= pos + 1'b1;
        else if (sof)  cnt <= '0;
    end

    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
        // Store byte k when its strobe arrives.
        always_ff @(posedge clk) begin
            if (!rst_n)                           held[k] <= '0;
            else if (take && pos == CNT_W'(k))    held[k] <= byte_in;
        end
        // Present the incoming byte in place of the stored one.
        assign da_now[k*BYTE_W +: BYTE_W] =
            (take && pos == CNT_W'(k)) ? byte_in : held[k];
    end
endmodule

// File: rtl/da_hash_index.sv
// Folds the address into a table index: bit n is the XOR of every
// IDX_W-th address bit starting at bit n. Assumes DA_W is a multiple of IDX_W.
module da_hash_index #(
    parameter int DA_W  = 48,
    parameter int IDX_W = 6,
    localparam int FOLDS = DA_W / IDX_W
) (
    input  logic [DA_W-1:0]  da,
    output logic [IDX_W-1:0] idx
);
    // XOR fold of the address into IDX_W bits.
    always_comb begin
        idx = '0;
        for (int i = 0; i < FOLDS; i++)
            for (int n = 0; n < IDX_W; n++)
                idx[n] = idx[n] ^ da[i*IDX_W + n];
    end
endmodule

// File: rtl/da_accept_decide.sv
// Combines broadcast, station, hash and copy-all results into one verdict.
// Priority: copy-all, broadcast (accept or reject), station, hash.
// Assumes da[0] is the group (multicast) bit.
module da_accept_decide
    import da_filt_pkg::*;
#(
    parameter int DA_W  = 48,
    parameter int IDX_W = 6,
    localparam int TBL_W = 1 << IDX_W
) (
    input  logic [DA_W-1:0]  da,
    input  logic [IDX_W-1:0] idx,
    input  logic [TBL_W-1:0] table_bits,
    input  logic [DA_W-1:0]  station,
    input  logic             uc_hash_en,
    input  logic             mc_hash_en,
    input  logic             copy_all,
    input  logic             no_bcast,
    output logic             accept,
    output match_kind_e      kind
);
    logic is_bcast, sta_hit, hash_hit;

    // Per-rule hits.
    always_comb begin
        is_bcast = &da;
        sta_hit  = (da == station);
        hash_hit = table_bits[idx] && (da[0] ? mc_hash_en : uc_hash_en);
    end

    // Priority resolution.
    always_comb begin
        if (copy_all)      kind = MK_PROMISC;
        else if (is_bcast) kind = no_bcast ? MK_NONE : MK_BCAST;
        else if (sta_hit)  kind = MK_STATION;
        else if (hash_hit) kind = MK_HASH;
        else               kind = MK_NONE;
        accept = (kind != MK_NONE);
    end
endmodule

// File: rtl/da_hash_filter.sv
// Destination address filter top: collects six address bytes, hashes and
// compares them, and registers the verdict one cycle after the last byte.
// Assumes configuration inputs are stable while an address is collected.
module da_hash_filter
    import da_filt_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int N_BYTES = 6,
    parameter int IDX_W   = 6,
    localparam int DA_W   = BYTE_W * N_BYTES,
    localparam int TBL_W  = 1 << IDX_W,
    localparam int HALF_W = TBL_W / 2,
    localparam int STL_W  = 32,
    localparam int STH_W  = DA_W - STL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [HALF_W-1:0] hash_lo,
    input  logic [HALF_W-1:0] hash_hi,
    input  logic [STL_W-1:0]  sta_lo,
    input  logic [STH_W-1:0]  sta_hi,
    input  logic              uc_hash_en,
    input  logic              mc_hash_en,
    input  logic              copy_all,
    input  logic              no_bcast,
    output logic              res_vld,
    output logic              accept,
    output logic [2:0]        match_kind
);
    logic [DA_W-1:0]  da_now;
    logic             last_byte;
    logic [IDX_W-1:0] idx;
    logic             acc_c;
    match_kind_e      kind_c;

    da_addr_collect #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) i_collect (
        .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
        .byte_in(byte_in), .da_now(da_now), .last_byte(last_byte)
    );

    da_hash_index #(.DA_W(DA_W), .IDX_W(IDX_W)) i_index (
        .da(da_now), .idx(idx)
    );

    da_accept_decide #(.DA_W(DA_W), .IDX_W(IDX_W)) i_decide (
        .da(da_now), .idx(idx), .table_bits({hash_hi, hash_lo}),
        .station({sta_hi, sta_lo}), .uc_hash_en(uc_hash_en),
        .mc_hash_en(mc_hash_en), .copy_all(copy_all), .no_bcast(no_bcast),
        .accept(acc_c), .kind(kind_c)
    );

    // Verdict register: pulse valid, hold accept and kind until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld    <= 1'b0;
            accept     <= 1'b0;
            match_kind <= 3'(MK_NONE);
        end else begin
            res_vld <= last_byte;
            if (last_byte) begin
                accept     <= acc_c;
                match_kind <= 3'(kind_c);
            end
        end
    end
endmodule

// File: rtl/da_hash_filter_chk.sv
// Property checker for da_hash_filter, attached by bind.
module da_hash_filter_chk
    import da_filt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       copy_all,
    input logic       no_bcast,
    input logic       res_vld,
    input logic       accept,
    input logic [2:0] match_kind
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!res_vld && !accept && match_kind == 3'(MK_NONE)));

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |=> !res_vld);

    // R2
    hold_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> ($stable(accept) && $stable(match_kind)));

    // R11
    accept_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept == (match_kind != 3'(MK_NONE)));

    // R9
    copy_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> ($past(copy_all) == (match_kind == 3'(MK_PROMISC))));

    // R8
    bcast_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && match_kind == 3'(MK_BCAST)) |-> !$past(no_bcast));
endmodule

bind da_hash_filter da_hash_filter_chk i_chk (
    .clk(clk), .rst_n(rst_n), .copy_all(copy_all), .no_bcast(no_bcast),
    .res_vld(res_vld), .accept(accept), .match_kind(match_kind)
);

// File: tb/test_da_hash_filter.sv
module test_da_hash_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0, byte_vld = 1'b0;
    logic [7:0]  byte_in = '0;
    logic [31:0] hash_lo = '0, hash_hi = '0, sta_lo = '0;
    logic [15:0] sta_hi = '0;
    logic        uc_hash_en = 1'b0, mc_hash_en = 1'b0, copy_all = 1'b0, no_bcast = 1'b0;
    logic        res_vld, accept;
    logic [2:0]  match_kind;

    int total = 0, bad = 0;
    logic       snap_vld, snap_acc;
    logic [2:0] snap_kind;

    da_hash_filter i_da_hash_filter (.*);

    always #5 clk = ~clk;

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [5:0] hidx(logic [47:0] da);
        logic [5:0] r = '0;
        for (int i = 0; i < 8; i++)
            for (int n = 0; n < 6; n++) r[n] ^= da[6*i + n];
        return r;
    endfunction

    task automatic set_bit(int b);
        hash_lo = '0; hash_hi = '0;
        if (b < 32) hash_lo[b] = 1'b1; else hash_hi[b-32] = 1'b1;
    endtask

    task automatic clear_cfg();
        hash_lo = '0; hash_hi = '0; sta_lo = 32'h33221100; sta_hi = 16'h5544;
        uc_hash_en = 0; mc_hash_en = 0; copy_all = 0; no_bcast = 0;
    endtask

    // Send one address plus 'extra' surplus strobes; snapshot the verdict.
    task automatic push_addr(logic [47:0] da, int extra);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            sof = (k == 0); byte_vld = 1'b1; byte_in = da[8*k +: 8];
        end
        @(negedge clk);
        snap_vld = res_vld; snap_acc = accept; snap_kind = match_kind;
        sof = 1'b0; byte_vld = (extra > 0); byte_in = 8'hFF;
        for (int e = 0; e < extra; e++) begin
            @(negedge clk);
            check("R10 surplus byte no verdict", res_vld, 0);
        end
        byte_vld = 1'b0;
        @(negedge clk);
        check("R2 pulse one cycle", res_vld, 0);
        check("R2 verdict held", accept, snap_acc);
    endtask

    task automatic expect_kind(string req, logic [47:0] da, int kind);
        push_addr(da, 0);
        check({req, " valid"}, snap_vld, 1);
        check({req, " accept"}, snap_acc, kind != 0);
        check({req, " kind"}, snap_kind, kind);
    endtask

    task automatic t_reset();
        check("R1 res_vld", res_vld, 0);
        check("R1 accept", accept, 0);
        check("R1 kind", match_kind, 0);
    endtask

    task automatic t_station();
        clear_cfg();
        expect_kind("R3 station", 48'h5544_3322_1100, 1);
        expect_kind("R11 one byte off", 48'h5544_3322_1101, 0);
        expect_kind("R3 reversed order", 48'h0011_2233_4455, 0);
    endtask

    task automatic t_hash_sweep();
        logic [47:0] da;
        clear_cfg(); mc_hash_en = 1;
        for (int c = 0; c < 8; c++) begin
            da = 48'h0135_79BD_F001 ^ (48'h0000_1234_5600 * (c + 1));
            da[0] = 1'b1;
            set_bit(int'(hidx(da)));
            expect_kind("R4 own bit", da, 3);
            hash_lo = ~hash_lo; hash_hi = ~hash_hi;
            expect_kind("R4 other bits", da, 0);
        end
    endtask

    task automatic t_mc_uc();
        logic [47:0] mc = 48'h0102_0304_5E01;
        logic [47:0] uc = 48'h0A0B_0C0D_0E10;
        clear_cfg();
        set_bit(int'(hidx(mc)));
        mc_hash_en = 1; expect_kind("R5 mc enabled", mc, 3);
        mc_hash_en = 0; uc_hash_en = 1; expect_kind("R5 uc_en ignored for mc", mc, 0);
        set_bit(int'(hidx(uc)));
        expect_kind("R6 uc enabled", uc, 3);
        uc_hash_en = 0; mc_hash_en = 1; expect_kind("R6 mc_en ignored for uc", uc, 0);
    endtask

    task automatic t_all_mc();
        clear_cfg(); hash_lo = '1; hash_hi = '1; mc_hash_en = 1;
        expect_kind("R5 all ones mc a", 48'hDEAD_BEEF_0003, 3);
        expect_kind("R5 all ones mc b", 48'h1234_5678_9A07, 3);
        expect_kind("R11 all ones uc off", 48'h1234_5678_9A06, 0);
    endtask

    task automatic t_bcast();
        clear_cfg();
        expect_kind("R7 bcast", '1, 2);
        hash_lo = '1; hash_hi = '1; mc_hash_en = 1; uc_hash_en = 1;
        sta_lo = '1; sta_hi = '1; no_bcast = 1;
        expect_kind("R8 bcast rejected", '1, 0);
    endtask

    task automatic t_copy_all();
        clear_cfg(); copy_all = 1;
        expect_kind("R9 random addr", 48'h0F1E_2D3C_4B5A, 4);
        no_bcast = 1; expect_kind("R9 bcast with no_bcast", '1, 4);
        expect_kind("R9 station addr", 48'h5544_3322_1100, 4);
    endtask

    task automatic t_surplus_restart();
        clear_cfg();
        push_addr(48'h5544_3322_1100, 3);
        check("R10 surplus valid", snap_vld, 1);
        check("R10 surplus kind", snap_kind, 1);
        // partial address abandoned by sof
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); sof = (k == 0); byte_vld = 1; byte_in = 8'h77;
        end
        expect_kind("R10 restart", 48'h5544_3322_1100, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_cfg();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_station();
        t_hash_sweep();
        t_mc_uc();
        t_all_mc();
        t_bcast();
        t_copy_all();
        t_surplus_restart();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule